// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge

This block gathers a parameterized set of level-sensitive interrupt inputs and drives a single interrupt request toward one processor. Software reaches it through a simple 32-bit register bus split into two windows. The global window selects the arbitration mode, holds the per-source enables and holds each source's priority. The processor window holds the task-priority threshold, the per-source masks, the acknowledge register and a small doorbell cause register.

Enables and masks are changed one source at a time. Software writes a source number to a dedicated set or clear offset; it does not write a bit vector. Each source also has its own control word that carries its 4-bit priority and a copy of its enable flag. When the request line is raised, the processor reads the acknowledge register to learn which source to service. That read has no side effect. A source keeps qualifying for as long as its input stays high.

Bus access: `bus_cpu` selects the window (0 = global, 1 = processor). A write commits on the clock edge where `bus_wr` is high. Read data is a combinational function of the window, the offset and the current state.

Top module: `pic_top`

## Requirements
- R1: After reset, all enables are clear, every source is masked, all priorities, the task priority and the doorbell bits are zero, and hardware priority selection is off. The global control word at offset 0x000 reads with bit 0 = mode and bits 11:2 = the number of implemented sources.
- R2: In the global window, writing a source number to 0x030 sets that source's enable and writing it to 0x034 clears it. The enable reads back as bit 28 of that source's control word.
- R3: Source n's control word sits at global offset 0x100 + 4*n. Bits 27:24 are its priority and bit 28 is its enable. All other bits read zero, so a read-modify-write of the priority keeps the enable.
- R4: In the processor window, writing a source number to 0x048 masks that source and writing it to 0x04C unmasks it. A masked source is never acknowledged.
- R5: The task priority occupies bits 31:28 at processor offset 0x040. With priority selection on, a source qualifies only if its priority is strictly above the task priority.
- R6: With control bit 0 = 1, the acknowledge register (processor offset 0x044) returns in bits 9:0 the qualifying source with the highest priority. A tie goes to the lower source number.
- R7: With control bit 0 = 0, both the priority and the task-priority comparison are skipped, and the acknowledge returns the lowest-numbered source that is asserted, enabled and unmasked.
- R8: When no source qualifies, the acknowledge returns 1023.
- R9: `irq` is high exactly one clock after a cycle in which some source qualifies. With `REG_IRQ` = 0 it follows in the same cycle.
- R10: A set or clear write (enable or mask) whose value is at or beyond the number of sources changes nothing.
- R11: Offsets that decode to no register read as zero, and writes to them change no state.
- R12: Doorbell cause is at processor offset 0x008. A high `db_set` bit sets the matching cause bit. A write keeps only the cause bits whose write-data bit is 1, so writing zero clears them all. A set in the same cycle as a write takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Level interrupt inputs |
| db_set | input | DB_W | Doorbell cause set pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_cpu | input | 1 | Window select, 1 = processor window |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench sweeps every input pattern of an eight-source configuration under several threshold and mode settings, with two sources sharing a priority. An arbiter that breaks ties toward the higher number, or that lets a source equal to the threshold through, would return the wrong ID on those patterns. Out-of-range set and clear values are written and the whole register state is read back afterwards, which catches index wrap-around that would corrupt a low source. The doorbell write-to-keep semantics and the one-cycle lag of `irq` are checked at the exact cycle, so an inverted keep mask or a missing pipeline stage shows up.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 4;
  localparam logic [ID_W-1:0] NO_SRC = 10'd1023;

  // global window
  localparam logic [11:0] G_CTRL    = 12'h000;
  localparam logic [11:0] G_EN_SET  = 12'h030;
  localparam logic [11:0] G_EN_CLR  = 12'h034;
  localparam logic [11:0] G_SRC_BASE = 12'h100;
  // processor window
  localparam logic [11:0] P_DOORBELL = 12'h008;
  localparam logic [11:0] P_TASKPRI  = 12'h040;
  localparam logic [11:0] P_ACK      = 12'h044;
  localparam logic [11:0] P_MSK_SET  = 12'h048;
  localparam logic [11:0] P_MSK_CLR  = 12'h04C;

  localparam int SRC_PRIO_LSB = 24;
  localparam int SRC_EN_BIT   = 28;
  localparam int TASK_LSB     = 28;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DB_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [DB_W-1:0]                   db_set,
  input  logic                              bus_wr,
  input  logic                              bus_cpu,
  input  logic [11:0]                       bus_addr,
  input  logic [31:0]                       bus_wdata,
  input  logic [ID_W-1:0]                   sel_id,
  output logic [31:0]                       bus_rdata,
  output logic [NUM_SRC-1:0]                en_q,
  output logic [NUM_SRC-1:0]                mask_q,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_q,
  output logic [PRIO_W-1:0]                 tp_q,
  output logic                              prio_en_q,
  output logic [DB_W-1:0]                   db_q
);
  logic [NUM_SRC-1:0]             en_n, mask_n;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_n;
  logic [PRIO_W-1:0]              tp_n;
  logic                           prio_en_n;
  logic [DB_W-1:0]                db_n;
  logic                           wr_g, wr_p;

  assign wr_g = bus_wr && !bus_cpu;
  assign wr_p = bus_wr &&  bus_cpu;

  always_comb begin
    en_n      = en_q;
    mask_n    = mask_q;
    prio_n    = prio_q;
    tp_n      = tp_q;
    prio_en_n = prio_en_q;
    db_n      = db_q;
    if (wr_g && bus_addr == G_CTRL) prio_en_n = bus_wdata[0];
    if (wr_p && bus_addr == P_TASKPRI) tp_n = bus_wdata[TASK_LSB +: PRIO_W];
    if (wr_p && bus_addr == P_DOORBELL) db_n = db_q & bus_wdata[DB_W-1:0];
    db_n = db_n | db_set;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (bus_wdata == 32'(i)) begin
        if (wr_g && bus_addr == G_EN_SET)  en_n[i]   = 1'b1;
        if (wr_g && bus_addr == G_EN_CLR)  en_n[i]   = 1'b0;
        if (wr_p && bus_addr == P_MSK_SET) mask_n[i] = 1'b1;
        if (wr_p && bus_addr == P_MSK_CLR) mask_n[i] = 1'b0;
      end
      if (wr_g && bus_addr == 12'(G_SRC_BASE + 12'(4 * i))) begin
        prio_n[i] = bus_wdata[SRC_PRIO_LSB +: PRIO_W];
        en_n[i]   = bus_wdata[SRC_EN_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      mask_q    <= '1;
      prio_q    <= '0;
      tp_q      <= '0;
      prio_en_q <= 1'b0;
      db_q      <= '0;
    end else begin
      en_q      <= en_n;
      mask_q    <= mask_n;
      prio_q    <= prio_n;
      tp_q      <= tp_n;
      prio_en_q <= prio_en_n;
      db_q      <= db_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_cpu) begin
      if (bus_addr == G_CTRL) begin
        bus_rdata[0]    = prio_en_q;
        bus_rdata[11:2] = 10'(NUM_SRC);
      end
      for (int i = 0; i < NUM_SRC; i++) begin
        if (bus_addr == 12'(G_SRC_BASE + 12'(4 * i))) begin
          bus_rdata[SRC_PRIO_LSB +: PRIO_W] = prio_q[i];
          bus_rdata[SRC_EN_BIT]             = en_q[i];
        end
      end
    end else begin
      if (bus_addr == P_TASKPRI)  bus_rdata[TASK_LSB +: PRIO_W] = tp_q;
      if (bus_addr == P_ACK)      bus_rdata[ID_W-1:0] = sel_id;
      if (bus_addr == P_DOORBELL) bus_rdata[DB_W-1:0] = db_q;
    end
  end
endmodule

// File: rtl/pic_select.sv
module pic_select
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0]             src_in,
  input  logic [NUM_SRC-1:0]             en_q,
  input  logic [NUM_SRC-1:0]             mask_q,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q,
  input  logic [PRIO_W-1:0]              tp_q,
  input  logic                           prio_en_q,
  output logic                           sel_valid,
  output logic [ID_W-1:0]                sel_id
);
  logic [NUM_SRC-1:0] live;
  logic [PRIO_W-1:0]  best_prio;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      live[i] = src_in[i] && en_q[i] && !mask_q[i]
                && (!prio_en_q || prio_q[i] > tp_q);
  end

  // ascending scan: replace only on strictly higher priority, so ties keep the lower number
  always_comb begin
    sel_valid = 1'b0;
    sel_id    = NO_SRC;
    best_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (live[i] && (!sel_valid || (prio_en_q && prio_q[i] > best_prio))) begin
        sel_valid = 1'b1;
        sel_id    = ID_W'(i);
        best_prio = prio_q[i];
      end
    end
  end
endmodule

// File: rtl/pic_irq_out.sv
module pic_irq_out #(
  parameter bit REG_IRQ = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_valid,
  output logic irq
);
  generate
    if (REG_IRQ) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= sel_valid;
      end
      assign irq = irq_q;
    end else begin : g_comb
      assign irq = sel_valid;
    end
  endgenerate
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DB_W    = 8,
  parameter bit REG_IRQ = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [DB_W-1:0]    db_set,
  input  logic               bus_wr,
  input  logic               bus_cpu,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq
);
  logic [NUM_SRC-1:0]             en_q, mask_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0]              tp_q;
  logic                           prio_en_q;
  logic [DB_W-1:0]                db_q;
  logic                           sel_valid;
  logic [ID_W-1:0]                sel_id;

  pic_regs #(.NUM_SRC(NUM_SRC), .DB_W(DB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .db_set(db_set), .bus_wr(bus_wr),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .sel_id(sel_id), .bus_rdata(bus_rdata), .en_q(en_q), .mask_q(mask_q),
    .prio_q(prio_q), .tp_q(tp_q), .prio_en_q(prio_en_q), .db_q(db_q)
  );

  pic_select #(.NUM_SRC(NUM_SRC)) u_sel (
    .src_in(src_in), .en_q(en_q), .mask_q(mask_q), .prio_q(prio_q),
    .tp_q(tp_q), .prio_en_q(prio_en_q), .sel_valid(sel_valid), .sel_id(sel_id)
  );

  pic_irq_out #(.REG_IRQ(REG_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .irq(irq)
  );
endmodule

// File: rtl/pic_chk.sv
module pic_chk
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DB_W    = 8,
  parameter bit REG_IRQ = 1'b1
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_SRC-1:0]               src_in,
  input logic [DB_W-1:0]                  db_set,
  input logic                             bus_wr,
  input logic                             bus_cpu,
  input logic [11:0]                      bus_addr,
  input logic [31:0]                      bus_wdata,
  input logic [31:0]                      bus_rdata,
  input logic                             irq,
  input logic [NUM_SRC-1:0]               en_q,
  input logic [NUM_SRC-1:0]               mask_q,
  input logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_q,
  input logic [PRIO_W-1:0]                tp_q,
  input logic                             prio_en_q,
  input logic [DB_W-1:0]                  db_q,
  input logic                             sel_valid,
  input logic [ID_W-1:0]                  sel_id
);
  logic [PRIO_W-1:0] sel_prio;
  always_comb begin
    sel_prio = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel_id == ID_W'(i)) sel_prio = prio_q[i];
  end

  // R4: a chosen source is always a live, enabled, unmasked one
  a_r4_live_source: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (|(src_in & en_q & ~mask_q)));

  a_r5_above_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && prio_en_q) |-> (sel_prio > tp_q));

  a_r8_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cpu && bus_addr == P_ACK && !sel_valid) |-> (bus_rdata[ID_W-1:0] == NO_SRC));

  a_r10_oob_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_cpu && (bus_addr == G_EN_SET || bus_addr == G_EN_CLR)
     && bus_wdata >= 32'(NUM_SRC)) |=> $stable(en_q));

  a_r10_oob_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_cpu && (bus_addr == P_MSK_SET || bus_addr == P_MSK_CLR)
     && bus_wdata >= 32'(NUM_SRC)) |=> $stable(mask_q));

  a_r12_db_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_cpu && bus_addr == P_DOORBELL && bus_wdata == 32'd0
     && db_set == '0) |=> (db_q == '0));

  generate
    if (REG_IRQ) begin : g_r9
      a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> irq);
      a_r9_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |=> !irq);
    end else begin : g_r9c
      a_r9_irq_now: assert property (@(posedge clk) disable iff (!rst_n)
        irq == sel_valid);
    end
  endgenerate
endmodule

bind pic_top pic_chk #(.NUM_SRC(NUM_SRC), .DB_W(DB_W), .REG_IRQ(REG_IRQ)) i_chk (
  .clk(clk), .rst_n(rst_n), .src_in(src_in), .db_set(db_set), .bus_wr(bus_wr),
  .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq(irq), .en_q(en_q), .mask_q(mask_q),
  .prio_q(prio_q), .tp_q(tp_q), .prio_en_q(prio_en_q), .db_q(db_q),
  .sel_valid(sel_valid), .sel_id(sel_id)
);

// File: tb/test_pic_top.sv
module test_pic_top;
  localparam int N = 8;
  localparam int DBW = 8;

  logic        clk, rst_n;
  logic [N-1:0] src_in;
  logic [DBW-1:0] db_set;
  logic        bus_wr, bus_cpu;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  bit       m_en[N];
  bit       m_msk[N];
  int       m_pri[N];
  int       m_tp;
  bit       m_pen;

  pic_top #(.NUM_SRC(N), .DB_W(DBW), .REG_IRQ(1'b1)) i_pic_top (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .db_set(db_set),
    .bus_wr(bus_wr), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit cpu, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_cpu = cpu; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(bit cpu, logic [11:0] a, output logic [31:0] d);
    bus_cpu = cpu; bus_addr = a; bus_wr = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  function automatic int exp_ack(logic [N-1:0] s);
    if (!m_pen) begin
      for (int i = 0; i < N; i++)
        if (s[i] && m_en[i] && !m_msk[i]) return i;
      return 1023;
    end
    for (int p = 15; p > m_tp; p--)
      for (int i = 0; i < N; i++)
        if (s[i] && m_en[i] && !m_msk[i] && m_pri[i] == p) return i;
    return 1023;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src_in = '0; db_set = '0; bus_wr = 0; bus_cpu = 0;
    bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_msk[i] = 1; m_pri[i] = 0; end
    m_tp = 0; m_pen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    src_in = '1;
    @(negedge clk);

    // R1 reset state
    rd(0, 12'h000, d); check("R1 ctrl", d, 32'(N) << 2);
    rd(1, 12'h044, d); check("R1 ack", d, 32'd1023);
    check("R1 irq", {31'b0, irq}, 32'd0);
    rd(1, 12'h040, d); check("R1 taskpri", d, 32'd0);
    rd(1, 12'h008, d); check("R1 doorbell", d, 32'd0);
    for (int i = 0; i < N; i++) begin
      rd(0, 12'(12'h100 + 4 * i), d); check("R1 srcword", d, 32'd0);
    end

    // R2 set enables; R4 unmask; R3 priorities; tie between 0 and 7
    for (int i = 0; i < N; i++) begin
      wr(0, 12'h030, 32'(i)); m_en[i] = 1;
      wr(1, 12'h04C, 32'(i)); m_msk[i] = 0;
    end
    rd(0, 12'h104, d); check("R2 enable bit 28", d, 32'h1000_0000);
    for (int i = 0; i < N; i++) begin
      m_pri[i] = (i * 3) % 7 + 8;
      wr(0, 12'(12'h100 + 4 * i), 32'h1000_0000 | (32'(m_pri[i]) << 24) | 32'h00AB_CDEF);
      rd(0, 12'(12'h100 + 4 * i), d);
      check("R3 srcword readback", d, 32'h1000_0000 | (32'(m_pri[i]) << 24));
    end
    // R3 rmw of priority keeps enable
    wr(0, 12'h108, 32'h1000_0000 | (32'd14 << 24));
    rd(0, 12'h108, d); check("R3 rmw keeps enable", d, 32'h1E00_0000);

    // R10 out-of-range set/clear
    wr(0, 12'h034, 32'(N)); wr(0, 12'h034, 32'hFFFF_FFFF);
    wr(1, 12'h048, 32'(N)); wr(1, 12'h048, 32'h0000_0100);
    for (int i = 0; i < N; i++) begin
      rd(0, 12'(12'h100 + 4 * i), d);
      check("R10 enable untouched", d, 32'h1000_0000 | (32'(m_pri[i]) << 24));
    end
    // masks untouched: with tp=0, mode off, each single source must be acknowledged
    for (int i = 0; i < N; i++) begin
      src_in = N'(1) << i;
      rd(1, 12'h044, d); check("R10 mask untouched", d, 32'(i));
    end

    // R11 unmapped offsets
    wr(0, 12'h010, 32'hFFFF_FFFF);
    wr(1, 12'h100, 32'hFFFF_FFFF);
    rd(0, 12'h010, d); check("R11 unmapped global", d, 32'd0);
    rd(1, 12'h100, d); check("R11 unmapped cpu", d, 32'd0);
    rd(0, 12'(12'h100 + 4 * N), d); check("R11 beyond last src", d, 32'd0);
    rd(0, 12'h000, d); check("R11 ctrl unchanged", d, 32'(N) << 2);
    rd(1, 12'h040, d); check("R11 taskpri unchanged", d, 32'd0);

    // R2 clear enable of source 3
    wr(0, 12'h034, 32'd3); m_en[3] = 0;
    rd(0, 12'h10C, d); check("R2 cleared", d, 32'(m_pri[3]) << 24);
    src_in = 8'h08;
    rd(1, 12'h044, d); check("R2 disabled source not acked", d, 32'd1023);
    wr(0, 12'h030, 32'd3); m_en[3] = 1;

    // sweep: R5 R6 R7 R8 R9
    for (int mode = 0; mode < 4; mode++) begin
      case (mode)
        0: begin m_pen = 1; m_tp = 0; end
        1: begin m_pen = 1; m_tp = 10; end
        2: begin m_pen = 1; m_tp = 15; end
        default: begin m_pen = 0; m_tp = 10; end
      endcase
      wr(0, 12'h000, {31'b0, m_pen});
      wr(1, 12'h040, 32'(m_tp) << 28);
      if (mode == 3) begin wr(1, 12'h048, 32'd2); m_msk[2] = 1; end
      rd(1, 12'h040, d); check("R5 taskpri readback", d, 32'(m_tp) << 28);
      for (int p = 0; p < (1 << N); p++) begin
        @(negedge clk);
        src_in = N'(p);
        rd(1, 12'h044, d);
        if (mode == 3) check("R7 lowest number", d, 32'(exp_ack(N'(p))));
        else if (mode == 2) check("R8 none above threshold", d, 32'(exp_ack(N'(p))));
        else check("R6 R5 arbitration", d, 32'(exp_ack(N'(p))));
        @(negedge clk);
        check("R9 irq lag", {31'b0, irq}, {31'b0, exp_ack(N'(p)) != 1023});
      end
    end
    // R4 masked source never acked
    src_in = 8'h04;
    rd(1, 12'h044, d); check("R4 masked", d, 32'd1023);
    src_in = '0;

    // R12 doorbell
    @(negedge clk); db_set = 8'h05;
    @(negedge clk); db_set = 8'h00;
    rd(1, 12'h008, d); check("R12 set", d, 32'h05);
    wr(1, 12'h008, 32'h01);
    rd(1, 12'h008, d); check("R12 keep mask", d, 32'h01);
    @(negedge clk);
    bus_cpu = 1; bus_addr = 12'h008; bus_wdata = 32'd0; bus_wr = 1; db_set = 8'h80;
    @(negedge clk); bus_wr = 0; db_set = 8'h00;
    rd(1, 12'h008, d); check("R12 set wins over write", d, 32'h80);
    wr(1, 12'h008, 32'd0);
    rd(1, 12'h008, d); check("R12 clear all", d, 32'd0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule